// File: doc/BRIEF.md
# Core Run-State Controller

This block sits between a host register port and the data path of a serial peripheral core. It decides whether the core is held in reset, running, or paused. The host asks for a state by writing a 2-bit code. The block answers with a 3-bit status word. The two low bits hold the state now in force. Bit 2 is a ready flag, and it is low while a change is settling. The host must wait for the ready flag before it writes again. A write made while the flag is low is dropped, and a sticky flag records that this happened.

Leaving pause for reset is guarded. From pause, reset is reached only when the clear code is written on two consecutive clock cycles. A single clear write, or a plain reset-code write, leaves the core paused. A separate software-reset strobe forces reset at once, whatever else is going on. On entry to reset the block pulses a one-cycle flush output, which the data path uses to empty its FIFOs and zero its transfer counters. The core-enable output is high only in run. A hold output tells the data path to freeze while paused.

Top module: `core_run_ctrl`

## Requirements
- R1: After the synchronous reset input is released, the status state bits read 0 (reset), the ready bit reads 1, and core_en, core_hold, flush and ign_sticky all read 0.
- R2: Status word layout: bits [1:0] give the state (0 = reset, 1 = run, 3 = pause) and bit 2 is the ready flag. Code 2 is never shown as a state; it is the clear code.
- R3: A write accepted while ready is 1 drives ready low for exactly 4 clock cycles, starting the cycle after the write. During those cycles the old state stays visible. The new state appears in the same cycle that ready returns high. Writing the state already in force is also accepted and settles in the same way.
- R4: A write made while ready is 0 has no effect on the state, and it sets ign_sticky. Only the reset input or a software reset clears ign_sticky; later accepted writes leave it set.
- R5: In pause, writing the clear code (2) on two consecutive cycles starts a transition to reset. Ready falls the cycle after the second write, and reset appears 4 cycles after that.
- R6: In pause, a clear-code write that is not followed on the very next cycle by another clear-code write leaves the state at pause with ready high. A reset-code (0) write in pause is refused in the same way.
- R7: In run or in reset, a write of code 2 is taken as a request for reset.
- R8: A software-reset strobe shows reset with ready high on the next cycle. It also clears ign_sticky and pulses flush. It cancels any transition in progress and overrides a write in the same cycle.
- R9: flush is high for exactly one cycle: the cycle in which reset becomes visible, either after a settled transition to reset (including reset to reset) or after a software reset. It stays low on entry to run or pause.
- R10: core_en is high exactly while the visible state is run, and core_hold exactly while it is pause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_we | input | 1 | Host write strobe for the requested state |
| req_code | input | 2 | Requested state code (0 reset, 1 run, 2 clear, 3 pause) |
| swrst_we | input | 1 | Software-reset strobe, forces reset |
| stat_word | output | 3 | {ready, state[1:0]} |
| core_en | output | 1 | High while in run |
| core_hold | output | 1 | High while in pause, freezes the data path |
| flush | output | 1 | One-cycle pulse on entry to reset |
| ign_sticky | output | 1 | Set by a write dropped while not ready |

## Verification
Inputs are driven on the falling edge and held for one rising edge; every output is sampled on the falling edge after that. After an accepted write, the bench expects ready low, with the old state showing, at the four falling edges that follow the write edge. At the fifth it expects ready high with the new state, the matching core_en and core_hold, and flush only when the target is reset. One falling edge later it checks that flush has dropped. Refused, single-clear and ignored writes are checked at the very next falling edge. Software reset is checked at the next falling edge, and again several cycles later to confirm the cancelled transition never completes.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic [1:0] {
        RS_RESET = 2'd0,
        RS_RUN   = 2'd1,
        RS_PAUSE = 2'd3
    } run_state_e;

    localparam logic [1:0] CODE_RESET = 2'd0;
    localparam logic [1:0] CODE_RUN   = 2'd1;
    localparam logic [1:0] CODE_CLEAR = 2'd2;
    localparam logic [1:0] CODE_PAUSE = 2'd3;

    typedef struct packed {
        logic       start;
        logic       arm;
        logic       ignored;
        run_state_e target;
    } req_dec_t;

    function automatic req_dec_t decode_req(
        input run_state_e  cur,
        input logic        ready,
        input logic        we,
        input logic [1:0]  code,
        input logic        armed
    );
        req_dec_t d;
        d         = '0;
        d.target  = RS_RESET;
        if (we) begin
            if (!ready) begin
                d.ignored = 1'b1;
            end else if (cur == RS_PAUSE) begin
                case (code)
                    CODE_CLEAR: begin
                        if (armed) begin
                            d.start  = 1'b1;
                            d.target = RS_RESET;
                        end else begin
                            d.arm = 1'b1;
                        end
                    end
                    CODE_RUN: begin
                        d.start  = 1'b1;
                        d.target = RS_RUN;
                    end
                    CODE_PAUSE: begin
                        d.start  = 1'b1;
                        d.target = RS_PAUSE;
                    end
                    default: ;
                endcase
            end else begin
                d.start = 1'b1;
                case (code)
                    CODE_RUN:   d.target = RS_RUN;
                    CODE_PAUSE: d.target = RS_PAUSE;
                    default:    d.target = RS_RESET;
                endcase
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/rsc_req_decode.sv
module rsc_req_decode
    import rsc_pkg::*;
(
    input  run_state_e cur_state,
    input  logic       ready,
    input  logic       we,
    input  logic [1:0] code,
    input  logic       armed,
    output req_dec_t   dec
);

    always_comb begin
        dec = decode_req(cur_state, ready, we, code, armed);
    end

endmodule

// File: rtl/rsc_clear_arm.sv
module rsc_clear_arm (
    input  logic clk,
    input  logic rst,
    input  logic abort,
    input  logic arm_set,
    output logic armed
);

    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= arm_set;
        end
    end

    assign armed = armed_q;

endmodule

// File: rtl/rsc_settle_timer.sv
module rsc_settle_timer #(
    parameter int SETTLE = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic abort,
    input  logic start,
    output logic ready,
    output logic done
);

    localparam int CW = $clog2(SETTLE + 1);
    localparam logic [CW-1:0] LOAD = CW'(SETTLE);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign ready = (cnt_q == '0);
    assign done  = (cnt_q == ONE);

    assert_start_idle_R3: assert property (@(posedge clk) disable iff (rst)
        start |-> ready);

    assert_done_not_ready_R3: assert property (@(posedge clk) disable iff (rst)
        (done && !abort) |=> ready);

endmodule

// File: rtl/core_run_ctrl.sv
module core_run_ctrl
    import rsc_pkg::*;
#(
    parameter int SETTLE = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_we,
    input  logic [1:0] req_code,
    input  logic       swrst_we,
    output logic [2:0] stat_word,
    output logic       core_en,
    output logic       core_hold,
    output logic       flush,
    output logic       ign_sticky
);

    run_state_e state_q;
    run_state_e pend_q;
    logic       flush_q;
    logic       ign_q;
    logic       ready;
    logic       done;
    logic       armed;
    req_dec_t   dec;

    rsc_req_decode u_dec (
        .cur_state (state_q),
        .ready     (ready),
        .we        (req_we),
        .code      (req_code),
        .armed     (armed),
        .dec       (dec)
    );

    rsc_clear_arm u_arm (
        .clk     (clk),
        .rst     (rst),
        .abort   (swrst_we),
        .arm_set (dec.arm),
        .armed   (armed)
    );

    rsc_settle_timer #(.SETTLE(SETTLE)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .abort (swrst_we),
        .start (dec.start),
        .ready (ready),
        .done  (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RS_RESET;
            pend_q  <= RS_RESET;
            flush_q <= 1'b0;
            ign_q   <= 1'b0;
        end else if (swrst_we) begin
            state_q <= RS_RESET;
            pend_q  <= RS_RESET;
            flush_q <= 1'b1;
            ign_q   <= 1'b0;
        end else begin
            flush_q <= 1'b0;
            if (dec.start) begin
                pend_q <= dec.target;
            end
            if (done) begin
                state_q <= pend_q;
                flush_q <= (pend_q == RS_RESET);
            end
            if (dec.ignored) begin
                ign_q <= 1'b1;
            end
        end
    end

    assign stat_word  = {ready, state_q};
    assign core_en    = (state_q == RS_RUN);
    assign core_hold  = (state_q == RS_PAUSE);
    assign flush      = flush_q;
    assign ign_sticky = ign_q;

    assert_flush_in_reset_R9: assert property (@(posedge clk) disable iff (rst)
        flush |-> (state_q == RS_RESET && ready));

    assert_flush_single_R9: assert property (@(posedge clk) disable iff (rst)
        (flush && !swrst_we) |=> !flush);

    assert_move_when_ready_R3: assert property (@(posedge clk) disable iff (rst)
        (!$stable(state_q) && !$past(swrst_we)) |-> ready);

    assert_drop_after_start_R3: assert property (@(posedge clk) disable iff (rst)
        (dec.start && !swrst_we) |=> !ready);

    assert_ignore_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (req_we && !ready && !swrst_we) |=> ign_sticky);

    assert_sticky_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (ign_sticky && !swrst_we) |=> ign_sticky);

    assert_single_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == RS_PAUSE && ready && req_we && req_code == CODE_CLEAR
         && !armed && !swrst_we) |=> (state_q == RS_PAUSE && ready));

    assert_soft_reset_R8: assert property (@(posedge clk) disable iff (rst)
        swrst_we |=> (state_q == RS_RESET && ready && flush && !ign_sticky));

endmodule

// File: tb/core_run_ctrl_tb.sv
module core_run_ctrl_tb;

    localparam int CLK_P  = 10;
    localparam int SETTLE = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_we;
    logic [1:0] req_code;
    logic       swrst_we;
    logic [2:0] stat_word;
    logic       core_en;
    logic       core_hold;
    logic       flush;
    logic       ign_sticky;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    core_run_ctrl #(.SETTLE(SETTLE)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .req_we     (req_we),
        .req_code   (req_code),
        .swrst_we   (swrst_we),
        .stat_word  (stat_word),
        .core_en    (core_en),
        .core_hold  (core_hold),
        .flush      (flush),
        .ign_sticky (ign_sticky)
    );

    // Vector fields: {code[1:0], expected state[1:0], ready drops, flush expected}
    localparam int NV = 12;
    localparam logic [5:0] VEC [NV] = '{
        {2'd1, 2'd1, 1'b1, 1'b0},   // reset -> run
        {2'd3, 2'd3, 1'b1, 1'b0},   // run -> pause
        {2'd0, 2'd3, 1'b0, 1'b0},   // reset code refused in pause (R6)
        {2'd1, 2'd1, 1'b1, 1'b0},   // pause -> run
        {2'd1, 2'd1, 1'b1, 1'b0},   // run -> run
        {2'd2, 2'd0, 1'b1, 1'b1},   // code 2 from run (R7)
        {2'd2, 2'd0, 1'b1, 1'b1},   // code 2 from reset (R7)
        {2'd0, 2'd0, 1'b1, 1'b1},   // reset -> reset
        {2'd3, 2'd3, 1'b1, 1'b0},   // reset -> pause
        {2'd3, 2'd3, 1'b1, 1'b0},   // pause -> pause
        {2'd1, 2'd1, 1'b1, 1'b0},   // pause -> run
        {2'd0, 2'd0, 1'b1, 1'b1}    // run -> reset
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_outputs(input string req, input int st);
        check({req, " state"}, int'(stat_word[1:0]), st);
        check({req, " core_en R10"}, int'(core_en), int'(st == 1));
        check({req, " core_hold R10"}, int'(core_hold), int'(st == 3));
    endtask

    // Called at the falling edge right after the start edge.
    task automatic check_window(input string req, input int old_st, input int new_st, input int exp_flush);
        for (int k = 0; k < SETTLE; k++) begin
            check({req, " ready low R3"}, int'(stat_word[2]), 0);
            check({req, " old state R3"}, int'(stat_word[1:0]), old_st);
            @(negedge clk);
        end
        check({req, " ready back R3"}, int'(stat_word[2]), 1);
        check_outputs(req, new_st);
        check({req, " flush R9"}, int'(flush), exp_flush);
        @(negedge clk);
        check({req, " flush drop R9"}, int'(flush), 0);
    endtask

    task automatic write1(input logic [1:0] code);
        req_we   = 1'b1;
        req_code = code;
        @(negedge clk);
        req_we   = 1'b0;
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R3 act=timeout exp=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cur;
        rst = 1'b1; req_we = 1'b0; req_code = 2'd0; swrst_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R2 reset state
        check("R1 state", int'(stat_word[1:0]), 0);
        check("R1 ready R2", int'(stat_word[2]), 1);
        check("R1 core_en", int'(core_en), 0);
        check("R1 core_hold", int'(core_hold), 0);
        check("R1 flush", int'(flush), 0);
        check("R1 sticky", int'(ign_sticky), 0);

        // Table walk (R2 R3 R6 R7 R9 R10)
        cur = 0;
        for (int i = 0; i < NV; i++) begin
            write1(VEC[i][5:4]);
            if (VEC[i][1]) begin
                check_window("R3 vec", cur, int'(VEC[i][3:2]), int'(VEC[i][0]));
            end else begin
                check("R6 refused ready", int'(stat_word[2]), 1);
                check_outputs("R6 refused", int'(VEC[i][3:2]));
                @(negedge clk);
            end
            cur = int'(VEC[i][3:2]);
        end

        // R5: two back-to-back clear writes from pause
        write1(2'd3);
        check_window("R5 setup", 0, 3, 0);
        req_we = 1'b1; req_code = 2'd2;
        @(negedge clk);
        check("R5 first clear keeps ready", int'(stat_word[2]), 1);
        check("R5 first clear keeps pause", int'(stat_word[1:0]), 3);
        @(negedge clk);
        req_we = 1'b0;
        check_window("R5 clear pair", 3, 0, 1);

        // R6: single clear write, then idle, then another lone clear
        write1(2'd3);
        check_window("R6 setup", 0, 3, 0);
        write1(2'd2);
        check("R6 single clear ready", int'(stat_word[2]), 1);
        check("R6 single clear state", int'(stat_word[1:0]), 3);
        @(negedge clk);
        check("R6 after idle state", int'(stat_word[1:0]), 3);
        check("R6 after idle ready", int'(stat_word[2]), 1);
        write1(2'd2);
        @(negedge clk);
        check("R6 split clears state", int'(stat_word[1:0]), 3);
        check("R6 split clears ready", int'(stat_word[2]), 1);

        // R4: write while not ready is dropped and sets sticky
        write1(2'd1);
        write1(2'd0);
        check("R4 sticky set", int'(ign_sticky), 1);
        repeat (SETTLE) @(negedge clk);
        check("R4 dropped write no effect", int'(stat_word[1:0]), 1);
        check("R4 ready", int'(stat_word[2]), 1);
        write1(2'd3);
        check_window("R4 later write", 1, 3, 0);
        check("R4 sticky persists", int'(ign_sticky), 1);

        // R8: software reset mid-transition with a write in the same cycle
        write1(2'd1);
        swrst_we = 1'b1; req_we = 1'b1; req_code = 2'd3;
        @(negedge clk);
        swrst_we = 1'b0; req_we = 1'b0;
        check("R8 state", int'(stat_word[1:0]), 0);
        check("R8 ready", int'(stat_word[2]), 1);
        check("R8 flush R9", int'(flush), 1);
        check("R8 sticky cleared", int'(ign_sticky), 0);
        @(negedge clk);
        check("R8 flush single R9", int'(flush), 0);
        repeat (SETTLE + 2) @(negedge clk);
        check("R8 cancelled state", int'(stat_word[1:0]), 0);
        check("R8 cancelled ready", int'(stat_word[2]), 1);
        check("R8 core_en R10", int'(core_en), 0);

        // R9: no flush when entering run
        write1(2'd1);
        check_window("R9 run entry", 0, 1, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule